// File: doc/BRIEF.md
# Operate-Class Microsequenced Datapath

This block executes the register-only "operate" instruction class of a 16-bit accumulator machine. Its results come from control equations evaluated on the low ten bits of the instruction word, called m7 through m16, where m16 is bit 0 and mK is bit (16-K). Opcodes are never looked up in a table, so every bit pattern, documented or not, yields a defined accumulator and carry result.

The datapath has one adder. Its first leg is either A or zero. Its second leg is either zero or all ones. A carry jam can turn the sum into an XOR, and a carry-in is derived from the instruction and C. A final phase merges the adder output D into A through byte-wise OR paths, some of them byte-swapped, and updates C.

A phase sequencer runs one of two passes:
- a normal pass of four phases;
- a six-phase pass, which repeats the adder step with A replaced by D.

The surrounding machine pulses `start` with the instruction, A and C. It waits for `done` and then takes the new A and C, plus a strobe that tells it to clear its shift count.

Top module: `opr_unit`

## Requirements
- R1: While reset is held and after its release, `busy`, `done` and `sc_clr` are 0, and `a_out` and `c_out` are 0.
- R2: A `start` sampled while idle is accepted, and `busy` is 1 from that edge on. Without a repeat pass (m8 and m15 not both set), `done` is 1 for exactly one cycle, on the 4th rising edge after the accepting edge, and `busy` is 0 again from that edge. With a repeat pass, both happen on the 6th edge.
- R3: A `start` asserted while `busy` is 1 is ignored. Result and timing are those of the instruction already accepted, and `a_out`/`c_out` change only on the edge that raises `done`.
- R4: Adder output D is formed as follows:
  - Leg 1 is A when any of m9, m11, m12 or m16 is set, and 0 otherwise.
  - Leg 2 is 0 when m9 or m11 is set, and 0xFFFF otherwise.
  - When m12 or m16 is set, D is leg1 XOR leg2.
  - Otherwise D is leg1 + leg2 + cin (mod 2^16), with cin = m15 AND (C OR NOT m13).
- R5: When m8 and m15 are both set, a repeat pass runs:
  - A takes D.
  - D becomes A + 0 + cin with no jam.
  - `sc_clr` is 1 in the `done` cycle.
  - Otherwise `sc_clr` stays 0.
- R6: The new A is built in this order:
  - Start from A, or from 0 if any of m11, m15 or m16 is set.
  - Clear bit 15 if m10 or m14 is set.
  - OR D[15:8] into bits 15:8 on (m11·m14)+m15+m16, and D[7:0] into bits 7:0 on (m11·m13)+m15+m16.
  - OR D[7:0] into bits 15:8 on m9·m11, and D[15:8] into bits 7:0 on m10·m11.
  - OR D[15] into bit 15 on (m8·m10)+m14.
- R7: The new C is derived as follows:
  - It starts as C.
  - When m9 is set and m11 is clear, it becomes the adder overflow. Overflow means either leg2 = 0xFFFF, cin = 0 and D = 0x7FFF, or leg2 = 0, cin = 1 and D = 0x8000. During a repeat pass leg2 counts as 0 and the jam as off.
  - It is forced to 1 on m8·m9, or on m10·m12 when D[15] = 1.
- R8: The documented encodings behave as intended:
  - octal 0140040 clears A;
  - 0140407 negates A (two's complement);
  - 0141340 swaps A's bytes;
  - 0140024 inverts A[15];
  - 0141206 adds 1 to A and sets C on signed overflow, otherwise clears C.
- R9: Instruction bits 15:10 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to execute an instruction, accepted only while idle |
| instr | input | 16 | Instruction word; bits 9:0 are m7..m16 |
| a_in | input | 16 | Accumulator value to operate on |
| c_in | input | 1 | Carry/overflow flag value to operate on |
| busy | output | 1 | Phase sequence in progress |
| done | output | 1 | One-cycle pulse; results valid and held afterwards |
| a_out | output | 16 | New accumulator |
| c_out | output | 1 | New carry/overflow flag |
| sc_clr | output | 1 | Shift-count clear strobe, with `done`, after a repeat pass |

## Verification
The assertions rely on the caller holding `instr`, `a_in` and `c_in` valid only in the cycle `start` is accepted. They also rely on the block latching these values itself, so input changes during `busy` must not reach the checked outputs. The stimulus obeys this: it raises `start` for one cycle while idle. In some vectors it also raises a second `start` with inverted operands during `busy`, to show that this does not disturb the result or its timing. The random sweep covers all 1024 combinations of m7..m16 several times over, with random A, C and upper instruction bits, so that every control term is exercised both with and without the repeat pass.

// File: rtl/opr_pkg.sv
package opr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T2R  = 3'd4,
    PH_T3R  = 3'd5,
    PH_T4   = 3'd6
  } phase_e;

  // Control word decoded from the instruction field
  typedef struct packed {
    logic leg1_en;    // leg 1 = A (else zero)
    logic leg2_zero;  // leg 2 = zero (else all ones)
    logic jam;        // force XOR, no carries
    logic cin;        // carry into adder
    logic rep;        // repeat adder pass
    logic clr_all;    // clear A in final phase
    logic clr_sign;   // clear A sign bit
    logic d_hi_hi;    // D high byte -> A high byte
    logic d_lo_lo;    // D low byte -> A low byte
    logic d_lo_hi;    // D low byte -> A high byte
    logic d_hi_lo;    // D high byte -> A low byte
    logic d_sgn;      // D sign -> A sign
    logic c_ovf;      // C takes adder overflow
    logic c_sgn;      // C set when D sign set
    logic c_set;      // C forced to one
  } ctl_t;

  localparam int FIELD_W = 10;

  // m-numbered bit select: m16 is bit 0, m7 is bit 9
  function automatic logic mbit(input logic [FIELD_W-1:0] f, input int k);
    return f[16-k];
  endfunction

endpackage

// File: rtl/opr_ctl.sv
module opr_ctl
  import opr_pkg::*;
(
  input  logic [FIELD_W-1:0] fld,
  input  logic               c_cur,
  output ctl_t               ctl
);

  logic m8, m9, m10, m11, m12, m13, m14, m15, m16;

  always_comb begin
    m8  = mbit(fld, 8);
    m9  = mbit(fld, 9);
    m10 = mbit(fld, 10);
    m11 = mbit(fld, 11);
    m12 = mbit(fld, 12);
    m13 = mbit(fld, 13);
    m14 = mbit(fld, 14);
    m15 = mbit(fld, 15);
    m16 = mbit(fld, 16);
  end

  always_comb begin
    ctl.leg2_zero = m9 | m11;
    ctl.jam       = m12 | m16;
    ctl.leg1_en   = m9 | m11 | m12 | m16;
    ctl.cin       = m15 & (c_cur | ~m13);
    ctl.rep       = m8 & m15;
    ctl.clr_all   = m11 | m15 | m16;
    ctl.clr_sign  = m10 | m14;
    ctl.d_hi_hi   = (m11 & m14) | m15 | m16;
    ctl.d_lo_lo   = (m11 & m13) | m15 | m16;
    ctl.d_lo_hi   = m9 & m11;
    ctl.d_hi_lo   = m10 & m11;
    ctl.d_sgn     = (m8 & m10) | m14;
    ctl.c_ovf     = m9 & ~m11;
    ctl.c_sgn     = m10 & m12;
    ctl.c_set     = m8 & m9;
  end

endmodule

// File: rtl/opr_adder.sv
module opr_adder #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic              leg1_en,
  input  logic              leg2_zero,
  input  logic              jam,
  input  logic              cin,
  output logic [DATA_W-1:0] d
);

  logic [DATA_W-1:0] leg1, leg2, sum;

  always_comb begin
    leg1 = leg1_en ? a : '0;
    leg2 = leg2_zero ? '0 : '1;
    sum  = leg1 + leg2 + DATA_W'(cin);
    d    = jam ? (leg1 ^ leg2) : sum;
  end

endmodule

// File: rtl/opr_compose.sv
module opr_compose
  import opr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] a_work,
  input  logic [DATA_W-1:0] d,
  input  logic              c_work,
  output logic [DATA_W-1:0] a_new,
  output logic              c_new
);

  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] base;
  logic [HALF-1:0]   hi_or, lo_or;
  logic              leg2_ones_eff, jam_eff, ovf;

  // Byte lanes: each half gathers its straight and swapped contributions
  always_comb begin
    hi_or = '0;
    lo_or = '0;
    if (ctl.d_hi_hi) hi_or = hi_or | d[DATA_W-1:HALF];
    if (ctl.d_lo_hi) hi_or = hi_or | d[HALF-1:0];
    if (ctl.d_lo_lo) lo_or = lo_or | d[HALF-1:0];
    if (ctl.d_hi_lo) lo_or = lo_or | d[DATA_W-1:HALF];
  end

  always_comb begin
    base = ctl.clr_all ? '0 : a_work;
    if (ctl.clr_sign) base[DATA_W-1] = 1'b0;
    base = base | {hi_or, lo_or};
    if (ctl.d_sgn) base[DATA_W-1] = base[DATA_W-1] | d[DATA_W-1];
    a_new = base;
  end

  // A repeat pass forces leg 2 to zero and disables the jam
  always_comb begin
    leg2_ones_eff = ~ctl.rep & ~ctl.leg2_zero;
    jam_eff       = ~ctl.rep & ctl.jam;
    ovf = ~jam_eff &
          ((leg2_ones_eff & ~ctl.cin & (d == MAX_POS)) |
           (~leg2_ones_eff & ctl.cin & (d == MIN_NEG)));
    c_new = c_work;
    if (ctl.c_ovf) c_new = ovf;
    if (ctl.c_set | (ctl.c_sgn & d[DATA_W-1])) c_new = 1'b1;
  end

endmodule

// File: rtl/opr_seq.sv
module opr_seq
  import opr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   rep,
  output phase_e phase,
  output logic   accept,
  output logic   busy,
  output logic   done
);

  phase_e phase_q, phase_d;
  logic   done_q, done_d;

  always_comb begin
    accept  = (phase_q == PH_IDLE) & start;
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = rep ? PH_T2R : PH_T4;
      PH_T2R:  phase_d = PH_T3R;
      PH_T3R:  phase_d = PH_T4;
      PH_T4:   phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
    done_d = (phase_q == PH_T4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign phase = phase_q;
  assign busy  = (phase_q != PH_IDLE);
  assign done  = done_q;

  assert_final_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T4) |=> done_q);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] a_in,
  input  logic              c_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] a_out,
  output logic              c_out,
  output logic              sc_clr
);

  phase_e              phase;
  logic                accept;
  ctl_t                ctl;
  logic [FIELD_W-1:0]  fld_q;
  logic                c_q;
  logic [DATA_W-1:0]   a_work_q, d_q, d_comb, a_new;
  logic                c_new;
  logic                add_leg1, add_leg2z, add_jam;
  logic                ld_fld, ld_awork, ld_d, ld_out;
  logic [DATA_W-1:0]   a_work_d;
  logic                sc_clr_q;

  opr_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .rep    (ctl.rep),
    .phase  (phase),
    .accept (accept),
    .busy   (busy),
    .done   (done)
  );

  opr_ctl u_ctl (
    .fld   (fld_q),
    .c_cur (c_q),
    .ctl   (ctl)
  );

  // Repeat pass: leg 1 = A, leg 2 = 0, jam off
  always_comb begin
    if (phase == PH_T3R) begin
      add_leg1  = 1'b1;
      add_leg2z = 1'b1;
      add_jam   = 1'b0;
    end else begin
      add_leg1  = ctl.leg1_en;
      add_leg2z = ctl.leg2_zero;
      add_jam   = ctl.jam;
    end
  end

  opr_adder #(.DATA_W(DATA_W)) u_add (
    .a         (a_work_q),
    .leg1_en   (add_leg1),
    .leg2_zero (add_leg2z),
    .jam       (add_jam),
    .cin       (ctl.cin),
    .d         (d_comb)
  );

  opr_compose #(.DATA_W(DATA_W)) u_cmp (
    .ctl    (ctl),
    .a_work (a_work_q),
    .d      (d_q),
    .c_work (c_q),
    .a_new  (a_new),
    .c_new  (c_new)
  );

  // Clock enables
  always_comb begin
    ld_fld   = accept;
    ld_awork = accept | (phase == PH_T2R);
    ld_d     = (phase == PH_T2) | (phase == PH_T3R);
    ld_out   = (phase == PH_T4);
    a_work_d = accept ? a_in : d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q    <= '0;
      c_q      <= 1'b0;
      a_work_q <= '0;
      d_q      <= '0;
      a_out    <= '0;
      c_out    <= 1'b0;
      sc_clr_q <= 1'b0;
    end else begin
      if (ld_fld) begin
        fld_q <= instr[FIELD_W-1:0];
        c_q   <= c_in;
      end
      if (ld_awork) a_work_q <= a_work_d;
      if (ld_d)     d_q      <= d_comb;
      if (ld_out) begin
        a_out <= a_new;
        c_out <= c_new;
      end
      sc_clr_q <= ld_out & ctl.rep;
    end
  end

  assign sc_clr = sc_clr_q;

  assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(a_out) && $stable(c_out)));

  assert_scclr_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_clr |-> done);

  assert_scclr_only_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(fld_q[8] && fld_q[1])) |-> !sc_clr);

  assert_cforce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fld_q[8] && fld_q[7]) |-> c_out);

endmodule

// File: tb/opr_unit_tb.sv
`timescale 1ns/1ps
module opr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] instr, a_in;
  logic        c_in;
  logic        busy, done, c_out, sc_clr;
  logic [15:0] a_out;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  opr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .a_in(a_in), .c_in(c_in), .busy(busy), .done(done),
    .a_out(a_out), .c_out(c_out), .sc_clr(sc_clr)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      finished = 1;
      $finish;
    end
  end

  function automatic bit m(input logic [15:0] w, input int k);
    return w[16-k];
  endfunction

  // Behavioural reference: returns {sc_clr, c, a}
  function automatic logic [17:0] ref_model(input logic [15:0] w, input logic [15:0] a, input logic c);
    int l1, l2, dd, res, cin, carry;
    bit jam, rep, ovf;
    l1  = (m(w,9) || m(w,11) || m(w,12) || m(w,16)) ? int'(a) : 0;
    l2  = (m(w,9) || m(w,11)) ? 0 : 65535;
    jam = m(w,12) || m(w,16);
    cin = (m(w,15) && (c || !m(w,13))) ? 1 : 0;
    dd  = jam ? (l1 ^ l2) : ((l1 + l2 + cin) % 65536);
    res = a;
    rep = m(w,8) && m(w,15);
    if (rep) begin
      res = dd;
      dd  = (res + cin) % 65536;
      l2  = 0;
      jam = 0;
    end
    if (m(w,11) || m(w,15) || m(w,16)) res = 0;
    if (m(w,10) || m(w,14)) res = res & 32767;
    if ((m(w,11) && m(w,14)) || m(w,15) || m(w,16)) res = res | (dd & 65280);
    if ((m(w,11) && m(w,13)) || m(w,15) || m(w,16)) res = res | (dd & 255);
    if (m(w,9) && m(w,11))  res = res | ((dd * 256) & 65280);
    if (m(w,10) && m(w,11)) res = res | (dd / 256);
    if ((m(w,8) && m(w,10)) || m(w,14)) res = res | (dd & 32768);
    carry = c;
    if (m(w,9) && !m(w,11)) begin
      ovf = !jam && (((l2 != 0) && cin == 0 && dd == 32767) ||
                     ((l2 == 0) && cin == 1 && dd == 32768));
      carry = ovf;
    end
    if ((m(w,8) && m(w,9)) || (m(w,10) && m(w,12) && dd >= 32768)) carry = 1;
    return {rep, carry[0], res[15:0]};
  endfunction

  task automatic check1(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Apply one instruction; optionally intrude with a second start while busy (R3).
  // m8 and m15 together select the 6-phase pass (R5); the timing check covers R2.
  task automatic apply(input logic [15:0] w, input logic [15:0] a, input logic c,
                       input bit intrude, input string tag,
                       input bit use_ref, input logic [15:0] exp_a, input logic exp_c);
    logic [17:0] e;
    int lat;
    e = ref_model(w, a, c);
    if (!use_ref) begin e[15:0] = exp_a; e[16] = exp_c; end
    lat = e[17] ? 6 : 4;
    @(negedge clk);
    instr = w; a_in = a; c_in = c; start = 1'b1;
    vectors++;
    for (int j = 0; j <= lat; j++) begin
      @(negedge clk);
      start = 1'b0;
      if (intrude && j == 0) begin
        start = 1'b1; instr = ~w; a_in = ~a; c_in = ~c;
      end
      check1({tag, " R2"}, "busy", int'(busy), (j < lat) ? 1 : 0);
      check1({tag, " R2"}, "done", int'(done), (j == lat) ? 1 : 0);
      if (j == lat) begin
        check1(tag, "a_out", int'(a_out), int'(e[15:0]));
        check1(tag, "c_out", int'(c_out), int'(e[16]));
        check1({tag, " R5"}, "sc_clr", int'(sc_clr), int'(e[17]));
      end
    end
    instr = '0; a_in = '0; c_in = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; instr = '0; a_in = '0; c_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1", "busy", int'(busy), 0);
    check1("R1", "done", int'(done), 0);
    check1("R1", "a_out", int'(a_out), 0);
    check1("R1", "c_out", int'(c_out), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check1("R1", "sc_clr", int'(sc_clr), 0);
    check1("R1", "busy after release", int'(busy), 0);

    // R8: documented encodings against intended effects (independent of model)
    apply(16'o140040, 16'h1234, 1'b1, 0, "R8 clear", 0, 16'h0000, 1'b1);
    apply(16'o140407, 16'h0005, 1'b0, 0, "R8 negate", 0, 16'hFFFB, 1'b0);
    apply(16'o140407, 16'h8000, 1'b1, 0, "R8 negate min", 0, 16'h8000, 1'b1);
    apply(16'o141340, 16'hA55A, 1'b0, 0, "R8 swap", 0, 16'h5AA5, 1'b0);
    apply(16'o141340, 16'h12F0, 1'b1, 0, "R8 swap", 0, 16'hF012, 1'b1);
    apply(16'o140024, 16'h7FFF, 1'b0, 0, "R8 sign flip", 0, 16'hFFFF, 1'b0);
    apply(16'o140024, 16'h8001, 1'b1, 0, "R8 sign flip", 0, 16'h0001, 1'b1);
    apply(16'o141206, 16'h0041, 1'b1, 0, "R8 incr", 0, 16'h0042, 1'b0);
    apply(16'o141206, 16'h7FFF, 1'b0, 0, "R8 R7 incr overflow", 0, 16'h8000, 1'b1);
    apply(16'o141206, 16'hFFFF, 1'b1, 0, "R8 R7 incr wrap", 0, 16'h0000, 1'b0);

    // R7: forced carry set and carry clear patterns
    apply(16'o140600, 16'h3333, 1'b0, 0, "R7 set C", 0, 16'h3333, 1'b1);
    apply(16'o140200, 16'h3333, 1'b1, 0, "R7 reset C", 0, 16'h3333, 1'b0);

    // R3: second start while busy is ignored
    apply(16'o140407, 16'h0010, 1'b0, 1, "R3 intrude", 0, 16'hFFF0, 1'b0);
    apply(16'o141340, 16'hBEEF, 1'b0, 1, "R3 intrude", 1, '0, 1'b0);

    // R9: upper bits ignored
    apply(16'o040407, 16'h0003, 1'b0, 0, "R9 upper bits", 0, 16'hFFFD, 1'b0);
    apply(16'o001340, 16'hC3A5, 1'b1, 0, "R9 upper bits", 0, 16'hA5C3, 1'b1);

    // R4/R6/R7/R5: every m7..m16 pattern, random A, C and upper bits
    for (int k = 0; k < 2048; k++) begin
      logic [15:0] w;
      w = {6'($urandom), 10'(k % 1024)};
      apply(w, 16'($urandom), 1'($urandom), (k % 7) == 3, "R4 R6 R7 sweep", 1, '0, 1'b0);
    end
    // R7 boundary: operands landing on overflow edges
    for (int k = 0; k < 1024; k++) begin
      apply({6'd0, 10'(k)}, 16'h7FFF, 1'(k), 0, "R7 edge", 1, '0, 1'b0);
      apply({6'd0, 10'(k)}, 16'h8000, 1'(k >> 1), 0, "R7 edge", 1, '0, 1'b0);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule